// File: doc/BRIEF.md
# Byte-Serial SPI Master Controller

This block is a small memory-mapped controller that moves one byte at a time over a four-wire SPI link. Software writes a control byte to choose enable, interrupt enable, master operation, clock idle level, sampling phase, open-drain pin drive and one of four serial clock rates. Writing the data register then starts an eight-bit exchange. The exchange sends the byte most significant bit first and collects the byte returned on the input line.

Three sticky status flags report progress and errors: byte complete, write collision and mode fault. Each flag clears only through a two-step access: a status read that sees the flag set, then a particular register access. An interrupt line follows the complete and fault flags whenever interrupts are enabled.

A low level on the slave-select input while the block is an enabled master means another master has taken the bus. The block then aborts at once, drops its enable and master bits, and releases its clock and data drive.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control register (address 0) and status register (address 1) read 0, both output enables are low and the interrupt line is low.
- R2: Control bits [7:6] select the serial clock half-period: codes 0, 1, 2 and 3 give 1, 2, 8 and 16 system clocks. A transfer takes exactly 16 half-periods from the data write to the complete flag.
- R3: Control bit 3 sets the clock idle level: with 1, sck_o rests high between transfers; with 0, it rests low.
- R4: Data goes out on mosi_o most significant bit first, with 8 bits per transfer. With control bit 4 at 0, data is valid before the first clock edge and is sampled on odd-numbered edges (1st, 3rd, ...). With bit 4 at 1, data changes on the first edge of each bit and is sampled on the second. The received byte reads at address 2 once status bit 0 is set.
- R5: Status bit 0 (complete) sets at the end of a transfer. It clears only when a status read that saw it set is followed by a read or write of address 2. An address-2 access with no such status read leaves it set.
- R6: A write to address 2 during a transfer sets status bit 1 (collision). The written byte is discarded and the current transfer is not disturbed. The bit clears by the same status-read-then-data-access sequence as R5.
- R7: With control bits 0 (enable) and 2 (master) both set, a low ss_n sets status bit 2 (mode fault). In the same cycle it clears control bits 0 and 2, aborts any transfer and deasserts both output enables.
- R8: The mode-fault bit clears only when a status read that saw it set is followed by a write to address 0. A control write with no such status read leaves it set.
- R9: With control bit 1 set, irq is high exactly while the complete or mode-fault flag is set. With bit 1 clear, irq stays low and the flags can still be read.
- R10: While control bit 0 or bit 2 is clear, sck_oe and mosi_oe stay low, so the pins are free for other use.
- R11: With control bit 5 set (open-drain), an output enable is high only while its output is low. With bit 5 clear, both enables stay high while the block is an enabled master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | 2 | 0 control, 1 status, 2 data |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the addressed register, combinational |
| ss_n | input | 1 | Slave-select input, low means another master owns the bus |
| miso | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_o | output | 1 | Serial data out level |
| mosi_oe | output | 1 | Serial data drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, the properties that hold at each clock edge. A fault always leaves the pins released and the enable bits cleared. A busy data write always raises the collision flag. The complete and fault flags never drop without the access that clears them. irq only rises with interrupts enabled. The enables stay low while disabled, and open-drain drive is never active on a high level. Only the bench scenarios can show the rest: the exact transfer length for each rate, the clock and data waveform in all four phase and polarity modes, the byte that comes back, and the end-to-end clearing sequences. The bench also shows that a discarded colliding byte never starts a later transfer.

// File: rtl/spi_ctl.sv
module spi_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ss_n,
  input  logic          miso,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          mosi_o,
  output logic          mosi_oe,
  output logic          irq
);
  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE);
  localparam int CW    = 5;

  logic [DW-1:0] ctrl_q, tx, rx, rxbuf;
  logic [CW-1:0] cnt, half_m1;
  logic [EW-1:0] ecount;
  logic          busy, sck_r;
  logic          st_done, st_wcol, st_mf;
  logic          arm_d, arm_w, arm_m;

  wire en     = ctrl_q[0];
  wire ie     = ctrl_q[1];
  wire master = ctrl_q[2];
  wire cpol   = ctrl_q[3];
  wire cpha   = ctrl_q[4];
  wire od     = ctrl_q[5];
  wire [1:0] rate = ctrl_q[7:6];

  always_comb begin
    case (rate)
      2'd0:    half_m1 = CW'(0);
      2'd1:    half_m1 = CW'(1);
      2'd2:    half_m1 = CW'(7);
      default: half_m1 = CW'(15);
    endcase
  end

  wire ctrl_wr  = sel & wr & (addr == 2'd0);
  wire stat_rd  = sel & ~wr & (addr == 2'd1);
  wire data_acc = sel & (addr == 2'd2);
  wire data_wr  = data_acc & wr;

  wire act     = en & master;
  wire fault   = act & ~ss_n;
  wire keep    = act & ~fault & ~(ctrl_wr & ~(wdata[0] & wdata[2]));
  wire tick    = (cnt == half_m1);
  wire step    = busy & keep & tick;
  wire finish  = step & (ecount == EW'(NEDGE - 1));
  wire start   = data_wr & ~busy & act & ~fault;
  wire collide = data_wr & busy;
  wire samp_e  = (ecount[0] == cpha);
  wire shift_e = cpha ? (~ecount[0] & (ecount != '0)) : ecount[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      ecount <= '0;
      sck_r  <= 1'b0;
      tx     <= '0;
      rx     <= '0;
      rxbuf  <= '0;
    end else begin
      if (fault) begin
        ctrl_q[0] <= 1'b0;
        ctrl_q[2] <= 1'b0;
      end else if (ctrl_wr) begin
        ctrl_q <= wdata;
      end

      if (start) busy <= 1'b1;
      else if (!keep || finish) busy <= 1'b0;

      if (start) begin
        tx     <= wdata;
        cnt    <= '0;
        ecount <= '0;
        sck_r  <= cpol;
      end else if (busy) begin
        if (tick) begin
          cnt    <= '0;
          ecount <= ecount + 1'b1;
          sck_r  <= ~sck_r;
          if (samp_e)  rx <= {rx[DW-2:0], miso};
          if (shift_e) tx <= {tx[DW-2:0], 1'b0};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      if (finish) rxbuf <= cpha ? {rx[DW-2:0], miso} : rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0;
      st_wcol <= 1'b0;
      st_mf   <= 1'b0;
      arm_d   <= 1'b0;
      arm_w   <= 1'b0;
      arm_m   <= 1'b0;
    end else begin
      if (finish) st_done <= 1'b1;
      else if (data_acc && arm_d) st_done <= 1'b0;

      if (collide) st_wcol <= 1'b1;
      else if (data_acc && arm_w) st_wcol <= 1'b0;

      if (fault) st_mf <= 1'b1;
      else if (ctrl_wr && arm_m) st_mf <= 1'b0;

      if (stat_rd) begin
        arm_d <= st_done;
        arm_w <= st_wcol;
      end else if (data_acc) begin
        arm_d <= 1'b0;
        arm_w <= 1'b0;
      end

      if (stat_rd) arm_m <= st_mf;
      else if (ctrl_wr) arm_m <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = DW'({st_mf, st_wcol, st_done});
      2'd2:    rdata = rxbuf;
      default: rdata = '0;
    endcase
  end

  assign sck_o   = busy ? sck_r : cpol;
  assign mosi_o  = tx[DW-1];
  assign sck_oe  = act & (~od | ~sck_o);
  assign mosi_oe = act & (~od | ~mosi_o);
  assign irq     = ie & (st_done | st_mf);
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [1:0] addr,
  input logic       busy,
  input logic       en,
  input logic       ie,
  input logic       master,
  input logic       od,
  input logic       st_done,
  input logic       st_mf,
  input logic       st_wcol,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       irq
);
  assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_mf) |-> (!en && !master && !sck_oe && !mosi_oe));

  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd2 && busy) |=> st_wcol);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !(sel && addr == 2'd2)) |=> st_done);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mf && !(sel && wr && addr == 2'd0)) |=> st_mf);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

  assert_pins_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sck_oe && !mosi_oe));

  assert_open_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (od && sck_oe) |-> !sck_o);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .busy(busy),
  .en(en), .ie(ie), .master(master), .od(od), .st_done(st_done),
  .st_mf(st_mf), .st_wcol(st_wcol), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .irq(irq)
);

// File: tb/sim_spi_ctl.sv
module sim_spi_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, sel = 1'b0, wr = 1'b0, ss_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, slv = '0;
  wire  [7:0] rdata;
  wire        miso, sck_o, sck_oe, mosi_o, mosi_oe, irq;
  int errors = 0, checks = 0;

  logic [7:0] m_ctrl, m_tx, m_rxbuf;
  logic       m_done, m_wcol, m_mf, m_ad, m_aw, m_am, m_busy;
  int         m_cnt, m_e;

  spi_ctl u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ss_n(ss_n), .miso(miso), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .irq(irq));

  assign miso = m_busy ? slv[7 - (m_e / 2)] : 1'b1;

  function automatic int mhalf(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_tx <= '0; m_rxbuf <= '0; m_busy <= 1'b0;
      m_done <= 1'b0; m_wcol <= 1'b0; m_mf <= 1'b0;
      m_ad <= 1'b0; m_aw <= 1'b0; m_am <= 1'b0; m_cnt <= 0; m_e <= 0;
    end else begin : model
      automatic bit act  = m_ctrl[0] && m_ctrl[2];
      automatic bit flt  = act && !ss_n;
      automatic bit cw   = sel && wr && addr == 2'd0;
      automatic bit sr   = sel && !wr && addr == 2'd1;
      automatic bit da   = sel && addr == 2'd2;
      automatic bit dw   = da && wr;
      automatic bit cont = act && !flt && !(cw && !(wdata[0] && wdata[2]));
      automatic bit last = (m_cnt == mhalf(m_ctrl[7:6]) - 1);
      automatic bit fin  = m_busy && cont && last && m_e == 15;
      if (flt) m_ctrl <= m_ctrl & 8'hFA;
      else if (cw) m_ctrl <= wdata;
      if (dw && !m_busy && act && !flt) begin
        m_busy <= 1'b1; m_cnt <= 0; m_e <= 0; m_tx <= wdata;
      end else if (m_busy) begin
        if (!cont || fin) m_busy <= 1'b0;
        if (last) begin m_cnt <= 0; m_e <= m_e + 1; end
        else m_cnt <= m_cnt + 1;
      end
      if (fin) m_rxbuf <= slv;
      if (fin) m_done <= 1'b1; else if (da && m_ad) m_done <= 1'b0;
      if (dw && m_busy) m_wcol <= 1'b1; else if (da && m_aw) m_wcol <= 1'b0;
      if (flt) m_mf <= 1'b1; else if (cw && m_am) m_mf <= 1'b0;
      if (sr) begin m_ad <= m_done; m_aw <= m_wcol; end
      else if (da) begin m_ad <= 1'b0; m_aw <= 1'b0; end
      if (sr) m_am <= m_mf; else if (cw) m_am <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin : cmp
      automatic bit act = m_ctrl[0] && m_ctrl[2];
      automatic bit od  = m_ctrl[5];
      automatic bit esck = m_busy ? (m_ctrl[3] ^ m_e[0]) : m_ctrl[3];
      automatic int idx = m_ctrl[4] ? ((m_e == 0) ? 0 : (m_e - 1) / 2) : m_e / 2;
      automatic bit emosi = m_tx[7 - idx];
      chk(sck_o == esck, m_busy ? "R2 sck timing" : "R3 sck idle level", sck_o, esck);
      chk(sck_oe == (act && (!od || !esck)), od ? "R11 sck drive" : "R10 sck drive",
          sck_oe, act && (!od || !esck));
      if (m_busy) begin
        chk(mosi_o == emosi, "R4 mosi bit", mosi_o, emosi);
        chk(mosi_oe == (act && (!od || !emosi)), od ? "R11 mosi drive" : "R10 mosi drive",
            mosi_oe, act && (!od || !emosi));
      end else if (!od || !act) begin
        chk(mosi_oe == act, "R10 mosi drive idle", mosi_oe, act);
      end
      chk(irq == (m_ctrl[1] && (m_done || m_mf)), "R9 irq", irq, m_ctrl[1] && (m_done || m_mf));
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] t, input logic [7:0] s);
    int n;
    logic [7:0] v;
    wr_reg(2'd0, c);
    slv = s;
    wr_reg(2'd2, t);
    wait_irq(n);
    chk(n == 16 * mhalf(c[7:6]), "R2 transfer length", n, 16 * mhalf(c[7:6]));
    rd_reg(2'd1, v); chk(v == 8'h01, "R5 complete set", v, 1);
    rd_reg(2'd2, v); chk(v == s, "R4 received byte", v, s);
    rd_reg(2'd1, v); chk(v == 8'h00, "R5 complete cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(sck_oe == 0 && mosi_oe == 0, "R1 enables low", {sck_oe, mosi_oe}, 0);
    chk(irq == 0, "R1 irq low", irq, 0);
    rd_reg(2'd0, v); chk(v == 0, "R1 control", v, 0);
    rd_reg(2'd1, v); chk(v == 0, "R1 status", v, 0);

    // R3 idle level both ways
    wr_reg(2'd0, 8'h0D); chk(sck_o == 1, "R3 idle high", sck_o, 1);
    wr_reg(2'd0, 8'h05); chk(sck_o == 0, "R3 idle low", sck_o, 0);

    // R2 R4 all rates and modes
    for (int i = 0; i < 16; i++) begin
      xfer({i[3:2], 1'b0, i[1], i[0], 3'b111}, 8'hA5 ^ 8'(i * 37), 8'h3C + 8'(i * 29));
    end

    // R5 data access without status read leaves complete set
    wr_reg(2'd0, 8'h07); slv = 8'h96; wr_reg(2'd2, 8'h5A); wait_irq(n);
    rd_reg(2'd2, v); rd_reg(2'd1, v); chk(v == 8'h01, "R5 still set", v, 1);
    rd_reg(2'd2, v); rd_reg(2'd1, v); chk(v == 8'h00, "R5 cleared", v, 0);

    // R6 collision
    wr_reg(2'd0, 8'h47); slv = 8'hC3; wr_reg(2'd2, 8'hA1);
    repeat (3) @(negedge clk);
    wr_reg(2'd2, 8'h5E); wait_irq(n);
    rd_reg(2'd1, v); chk(v == 8'h03, "R6 collision flag", v, 3);
    rd_reg(2'd2, v); chk(v == 8'hC3, "R6 transfer undisturbed", v, 8'hC3);
    rd_reg(2'd1, v); chk(v == 8'h00, "R6 flags cleared", v, 0);
    repeat (60) @(negedge clk);
    chk(irq == 0, "R6 discarded byte sent nothing", irq, 0);
    rd_reg(2'd1, v); chk(v == 8'h00, "R6 no later transfer", v, 0);

    // R9 interrupt disabled
    wr_reg(2'd0, 8'h05); slv = 8'h11; wr_reg(2'd2, 8'h22);
    repeat (30) @(negedge clk);
    chk(irq == 0, "R9 irq masked", irq, 0);
    rd_reg(2'd1, v); chk(v == 8'h01, "R9 polled complete", v, 1);
    rd_reg(2'd2, v);

    // R7 R8 mode fault while idle
    wr_reg(2'd0, 8'h07);
    @(negedge clk); ss_n = 1'b0; @(negedge clk); ss_n = 1'b1;
    chk(irq == 1, "R9 irq on fault", irq, 1);
    chk(sck_oe == 0 && mosi_oe == 0, "R7 pins released", {sck_oe, mosi_oe}, 0);
    rd_reg(2'd0, v); chk(v == 8'h02, "R7 enable and master cleared", v, 2);
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd1, v); chk(v == 8'h04, "R8 fault kept without status read", v, 4);
    wr_reg(2'd0, 8'h07);
    rd_reg(2'd1, v); chk(v == 8'h00, "R8 fault cleared", v, 0);
    chk(sck_oe == 1, "R8 drive restored", sck_oe, 1);

    // R7 fault aborts a transfer
    wr_reg(2'd0, 8'hC7); slv = 8'h0F; wr_reg(2'd2, 8'hF0);
    repeat (20) @(negedge clk);
    ss_n = 1'b0; @(negedge clk); ss_n = 1'b1;
    repeat (300) @(negedge clk);
    rd_reg(2'd1, v); chk(v == 8'h04, "R7 aborted without complete", v, 4);
    wr_reg(2'd0, 8'h07);

    // R10 pins free when disabled
    wr_reg(2'd0, 8'h00); chk(sck_oe == 0 && mosi_oe == 0, "R10 disabled", {sck_oe, mosi_oe}, 0);
    wr_reg(2'd0, 8'h04); chk(sck_oe == 0 && mosi_oe == 0, "R10 master only", {sck_oe, mosi_oe}, 0);
    wr_reg(2'd0, 8'h03); chk(sck_oe == 0, "R10 enabled slave", sck_oe, 0);

    // R11 open drain
    wr_reg(2'd0, 8'h2F); chk(sck_oe == 0, "R11 high level not driven", sck_oe, 0);
    wr_reg(2'd0, 8'h27); chk(sck_oe == 1, "R11 low level driven", sck_oe, 1);
    xfer(8'h2F, 8'h6B, 8'hD2);
    xfer(8'h77, 8'h94, 8'h2D);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule